// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Flush

This block paces a small two-stage microcontroller core. It divides the oscillator clock into four one-hot phase strobes per instruction cycle. During each cycle it fetches the next 16-bit program word while the current word is presented to the execute stage. At the last phase of every cycle it decides what the next cycle executes: the prefetched word, an injected no-op after a flush, or a second cycle that carries the operand word of a two-word instruction.

Execute reports three flags, which are sampled only in the last phase: a taken branch with its target, a true skip condition, and a two-word opcode. A taken branch or skip discards the prefetched word and puts an internal no-op slot in its place. A two-word opcode holds the first word for one more cycle and exposes the second word as an operand. A program word whose upper four bits are all ones is a second word that was reached on its own, and it runs as a no-op. The resulting instruction lengths are one, two or three cycles.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phase_o` is one-hot. It holds bit 0 after reset, moves up one bit per clock, and returns from bit 3 to bit 0, so one instruction cycle is four clocks.
- R2: After reset `pc_o` is 0, `instr_o` is 0, `instr_nop_o` is 1 and `operand_vld_o` is 0. The first cycle is a forced no-op while word 0 is fetched.
- R3: A slot that is not a no-op and raises no flag lasts one cycle. At its last-phase edge, `pc_o` increments by one and `instr_o` takes the value that was on `fetch_word_i`.
- R4: `branch_i` in the last phase of a non-no-op slot loads `pc_o` with `target_i`. The next slot is an injected no-op (`instr_nop_o`=1, `instr_o`=0), so a taken branch takes two cycles.
- R5: `skip_i` in the last phase of a non-no-op slot, without `branch_i`, discards the fetched word. `pc_o` increments and the next slot is an injected no-op.
- R6: `two_word_i` in the last phase of a real first-word slot (`operand_vld_o`=0), without branch or skip, makes the next slot keep `instr_o`. That slot shows the fetched word on `operand_o` with `operand_vld_o`=1, and `pc_o` increments.
- R7: A branch taken in the operand slot of a two-word instruction loads the target and is followed by one injected no-op, so the instruction takes three cycles.
- R8: When `operand_vld_o`=0 and `instr_o[15:12]` is 4'hF, the word is a stray second word. It is reported with `instr_nop_o`=1, and all three flags are ignored in that slot.
- R9: In any no-op slot, `branch_i`, `skip_i` and `two_word_i` have no effect. The next slot takes the fetched word and `pc_o` increments.
- R10: When several flags are raised together, branch wins over skip, and skip wins over two-word.
- R11: `pc_o` wraps from its all-ones value to 0.
- R12: The flags, target and fetch word are sampled only at the last-phase edge. `pc_o`, `instr_o`, `instr_nop_o` and `operand_vld_o` stay stable through the other phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_word_i | input | IW | Program word at address `pc_o` |
| branch_i | input | 1 | Execute: branch taken |
| target_i | input | AW | Execute: branch target address |
| skip_i | input | 1 | Execute: skip condition true |
| two_word_i | input | 1 | Execute: current opcode has a second word |
| phase_o | output | PHASES | One-hot phase strobes |
| pc_o | output | AW | Program counter (fetch address) |
| instr_o | output | IW | Word presented to execute |
| instr_nop_o | output | 1 | Current slot is a no-op |
| operand_o | output | IW | Second word of a two-word instruction |
| operand_vld_o | output | 1 | `operand_o` is valid in this slot |

## Verification
A wrong slot kind shows up at the ports within one instruction cycle. It appears as a no-op flag that is missing or raised in error, as an operand flag that persists, or as a word on `instr_o` that differs from the fetched one. A wrong program counter shows up at the next last-phase edge, because every later fetched word and instruction word then diverges from the reference program. A phase counter that is off by one shifts every sampling point, so the first cycle-level comparison after reset already fails.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic [1:0] {
    SLOT_REAL  = 2'd0,
    SLOT_FLUSH = 2'd1,
    SLOT_OPND  = 2'd2
  } slot_e;

  typedef enum logic [1:0] {
    ACT_SEQ  = 2'd0,
    ACT_JUMP = 2'd1,
    ACT_SKIP = 2'd2,
    ACT_PAIR = 2'd3
  } act_e;
endpackage

// File: rtl/ics_phase_gen.sv
module ics_phase_gen #(
  parameter int PHASES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PHASES-1:0] phase_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= PHASES'(1);
    else         phase_o <= {phase_o[PHASES-2:0], phase_o[PHASES-1]};
  end

  assign last_o = phase_o[PHASES-1];
endmodule

// File: rtl/ics_slot_ctrl.sv
module ics_slot_ctrl
  import ics_pkg::*;
#(
  parameter int IW     = 16,
  parameter int MARK_W = 4
) (
  input  slot_e          kind_i,
  input  logic [IW-1:0]  word_i,
  input  logic           branch_i,
  input  logic           skip_i,
  input  logic           two_word_i,
  output act_e           act_o,
  output logic           nop_o
);
  localparam logic [MARK_W-1:0] MARK = '1;

  logic stray;
  // a lone second word executes as a no-op
  assign stray = (kind_i == SLOT_REAL) && (word_i[IW-1 -: MARK_W] == MARK);
  assign nop_o = (kind_i == SLOT_FLUSH) || stray;

  always_comb begin
    act_o = ACT_SEQ;
    if (!nop_o) begin
      if (branch_i)                              act_o = ACT_JUMP;
      else if (skip_i)                           act_o = ACT_SKIP;
      else if (two_word_i && kind_i == SLOT_REAL) act_o = ACT_PAIR;
    end
  end
endmodule

// File: rtl/ics_pc_unit.sv
module ics_pc_unit #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_o <= '0;
    else if (adv_i) pc_o <= load_i ? target_i : pc_o + AW'(1);
  end
endmodule

// File: rtl/ics_ir_stage.sv
module ics_ir_stage
  import ics_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  act_e          act_i,
  input  logic [IW-1:0] fetch_word_i,
  output slot_e         kind_o,
  output logic [IW-1:0] ir_o,
  output logic [IW-1:0] opnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= SLOT_FLUSH;
      ir_o   <= '0;
      opnd_o <= '0;
    end else if (adv_i) begin
      unique case (act_i)
        ACT_JUMP, ACT_SKIP: begin
          kind_o <= SLOT_FLUSH;
          ir_o   <= '0;
        end
        ACT_PAIR: begin
          kind_o <= SLOT_OPND;
          opnd_o <= fetch_word_i;
        end
        default: begin
          kind_o <= SLOT_REAL;
          ir_o   <= fetch_word_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int AW     = 12,
  parameter int IW     = 16,
  parameter int PHASES = 4,
  parameter int MARK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     fetch_word_i,
  input  logic              branch_i,
  input  logic [AW-1:0]     target_i,
  input  logic              skip_i,
  input  logic              two_word_i,
  output logic [PHASES-1:0] phase_o,
  output logic [AW-1:0]     pc_o,
  output logic [IW-1:0]     instr_o,
  output logic              instr_nop_o,
  output logic [IW-1:0]     operand_o,
  output logic              operand_vld_o
);
  logic  last;
  slot_e kind;
  act_e  act;

  ics_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase_o),
    .last_o (last)
  );

  ics_slot_ctrl #(.IW(IW), .MARK_W(MARK_W)) u_ctrl (
    .kind_i    (kind),
    .word_i    (instr_o),
    .branch_i  (branch_i),
    .skip_i    (skip_i),
    .two_word_i(two_word_i),
    .act_o     (act),
    .nop_o     (instr_nop_o)
  );

  ics_pc_unit #(.AW(AW)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (last),
    .load_i  (act == ACT_JUMP),
    .target_i(target_i),
    .pc_o    (pc_o)
  );

  ics_ir_stage #(.IW(IW)) u_ir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (last),
    .act_i       (act),
    .fetch_word_i(fetch_word_i),
    .kind_o      (kind),
    .ir_o        (instr_o),
    .opnd_o      (operand_o)
  );

  assign operand_vld_o = (kind == SLOT_OPND);
endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk #(
  parameter int AW     = 12,
  parameter int IW     = 16,
  parameter int PHASES = 4,
  parameter int MARK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IW-1:0]     fetch_word_i,
  input logic              branch_i,
  input logic [AW-1:0]     target_i,
  input logic              skip_i,
  input logic              two_word_i,
  input logic [PHASES-1:0] phase_o,
  input logic [AW-1:0]     pc_o,
  input logic [IW-1:0]     instr_o,
  input logic              instr_nop_o,
  input logic [IW-1:0]     operand_o,
  input logic              operand_vld_o
);
  logic last;
  assign last = phase_o[PHASES-1];

  p_phase_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);

  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> phase_o[0]);

  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> phase_o == ($past(phase_o) << 1));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(pc_o) && $stable(instr_o) && $stable(instr_nop_o) && $stable(operand_vld_o));

  p_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !instr_nop_o && !branch_i && !skip_i && !(two_word_i && !operand_vld_o)
    |=> instr_o == $past(fetch_word_i) && pc_o == AW'($past(pc_o) + 1'b1) && !operand_vld_o);

  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !instr_nop_o && branch_i
    |=> pc_o == $past(target_i) && instr_nop_o && !operand_vld_o && instr_o == '0);

  p_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !instr_nop_o && !branch_i && skip_i
    |=> instr_nop_o && pc_o == AW'($past(pc_o) + 1'b1));

  p_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !instr_nop_o && !operand_vld_o && !branch_i && !skip_i && two_word_i
    |=> operand_vld_o && operand_o == $past(fetch_word_i) && instr_o == $past(instr_o));

  p_stray_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !operand_vld_o && instr_o[IW-1 -: MARK_W] == '1 |-> instr_nop_o);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && instr_nop_o
    |=> !operand_vld_o && pc_o == AW'($past(pc_o) + 1'b1) && instr_o == $past(fetch_word_i));
endmodule

bind instr_cycle_seq instr_cycle_seq_chk #(
  .AW(AW), .IW(IW), .PHASES(PHASES), .MARK_W(MARK_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_word_i (fetch_word_i),
  .branch_i     (branch_i),
  .target_i     (target_i),
  .skip_i       (skip_i),
  .two_word_i   (two_word_i),
  .phase_o      (phase_o),
  .pc_o         (pc_o),
  .instr_o      (instr_o),
  .instr_nop_o  (instr_nop_o),
  .operand_o    (operand_o),
  .operand_vld_o(operand_vld_o)
);

// File: tb/instr_cycle_seq_tb_top.sv
module instr_cycle_seq_tb_top;
  localparam int AW = 8;
  localparam int IW = 16;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [IW-1:0] fetch_word;
  logic          branch, skip, two_word;
  logic [AW-1:0] target;
  logic [PH-1:0] phase;
  logic [AW-1:0] pc;
  logic [IW-1:0] instr, operand;
  logic          instr_nop, operand_vld;

  instr_cycle_seq #(.AW(AW), .IW(IW), .PHASES(PH), .MARK_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_word_i(fetch_word), .branch_i(branch),
    .target_i(target), .skip_i(skip), .two_word_i(two_word), .phase_o(phase),
    .pc_o(pc), .instr_o(instr), .instr_nop_o(instr_nop), .operand_o(operand),
    .operand_vld_o(operand_vld)
  );

  // program image: every 13th address from 5 holds a stray second word (nibble F)
  function automatic logic [IW-1:0] memw(logic [AW-1:0] a);
    if (int'(a) % 13 == 5) return {4'hF, a[3:0], 8'(a * 7)};
    return 16'((32'(a) * 32'h9E37) ^ 32'h3C5A) & 16'h7FFF;
  endfunction

  assign fetch_word = memw(pc);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state: kind 0 real, 1 flush no-op, 2 operand slot
  int            m_kind;
  logic [AW-1:0] m_pc;
  logic [IW-1:0] m_ir, m_op;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    bit m_nop;
    m_nop = (m_kind == 1) || (m_kind == 0 && m_ir[15:12] == 4'hF);
    chk(tag, 32'(pc), 32'(m_pc), "pc");
    chk(tag, 32'(instr), 32'(m_ir), "instr");
    chk(tag, 32'(instr_nop), 32'(m_nop), "nop");
    chk(tag, 32'(operand_vld), 32'(m_kind == 2), "operand_vld");
    if (m_kind == 2) chk(tag, 32'(operand), 32'(m_op), "operand");
  endtask

  // one instruction cycle; entered and left at the falling edge in phase 0
  task automatic cyc(bit br, logic [AW-1:0] tg, bit sk, bit tw);
    bit m_nop;
    string tag;
    logic [IW-1:0] fw;
    for (int k = 0; k < PH; k++) begin
      chk("R1", 32'(phase), 32'(1 << k), "phase");
      if (k == PH - 1) begin
        branch = br; target = tg; skip = sk; two_word = tw;
      end else begin
        // junk before the last phase must not matter (R12)
        branch = 1'($urandom); target = AW'($urandom); skip = 1'($urandom); two_word = 1'($urandom);
      end
      @(negedge clk);
    end
    m_nop = (m_kind == 1) || (m_kind == 0 && m_ir[15:12] == 4'hF);
    fw = memw(m_pc);
    if (m_nop && m_kind == 0)             tag = "R8";
    else if (m_nop)                       tag = "R9";
    else if (br && (sk || tw))            tag = "R10";
    else if (br && m_kind == 2)           tag = "R7";
    else if (br)                          tag = "R4";
    else if (sk)                          tag = "R5";
    else if (tw && m_kind == 0)           tag = "R6";
    else if (m_pc == '1)                  tag = "R11";
    else                                  tag = "R3";
    if (!m_nop && br) begin
      m_kind = 1; m_ir = '0; m_pc = tg;
    end else if (!m_nop && sk) begin
      m_kind = 1; m_ir = '0; m_pc = m_pc + 1'b1;
    end else if (!m_nop && tw && m_kind == 0) begin
      m_kind = 2; m_op = fw; m_pc = m_pc + 1'b1;
    end else begin
      m_kind = 0; m_ir = fw; m_pc = m_pc + 1'b1;
    end
    chk_all(tag);
  endtask

  initial begin
    process::self().srandom(32'h1CE5);
    branch = 0; skip = 0; two_word = 0; target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_kind = 1; m_pc = '0; m_ir = '0; m_op = '0;
    chk_all("R2");
    chk("R2", 32'(phase), 32'h1, "phase");

    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);              // R3
    cyc(1, 8'hFE, 0, 0);                            // R4 branch
    cyc(1, 8'h33, 1, 1);                            // R9 flags in flush slot
    cyc(0, 0, 0, 0);
    chk("R11", 32'(pc), 32'h0, "wrap");
    cyc(0, 0, 0, 0);
    cyc(1, 8'd5, 0, 0); cyc(0, 0, 0, 0);            // land on stray word at 5
    cyc(1, 8'h44, 1, 1);                            // R8 ignored
    cyc(0, 0, 0, 1);                                // R6 two-word
    cyc(1, 8'd40, 0, 0);                            // R7 branch in operand slot
    chk("R7", 32'(instr_nop), 32'h1, "third cycle no-op");
    cyc(0, 0, 0, 0);
    cyc(1, 8'd90, 1, 1);                            // R10 branch wins
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 1);                                // R10 skip over two-word
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);                                // R5

    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 8) == 0, AW'($urandom), ($urandom % 8) == 0, ($urandom % 5) == 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule